// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Interface Controller

This block is a byte-wide serial peripheral port that sits on a simple special-function-register bus of a small processor. Software reaches it through three byte registers: control, status and data. As bus master it drives the serial clock from the system clock through a divider that software selects. It shifts one byte out while it shifts one byte in, and it can use any clock polarity, either clock phase and either bit order. As a slave it follows an external serial clock while the select input is low.

When a byte completes, a completion flag sets. That flag can raise an interrupt request, which is qualified by a local enable bit and by an external serial-interrupt enable. A write to the data register while a byte is moving is dropped and marks a collision. Both flags clear only through a fixed sequence: software reads the status register while a flag is set, and then accesses the data register. The pin output enables are registered and drop whenever the port is switched off.

Top module: `spi_port`

## Requirements
- R1: After reset the control register reads 0x04, the status register reads 0x00, the output enables `sck_oe`, `mosi_oe` and `miso_oe` are 0, and `irq_o` is 0.
- R2: `sfr_sel` picks the register: 0 selects control, 1 selects status and 2 selects data. `sfr_rdata` shows the selected register one cycle after a `sfr_rd` strobe. In the status register, bit 7 is the completion flag, bit 6 is the collision flag and bits 5..0 read 0.
- R3: Control bit layout: bit 7 interrupt enable, bit 6 port enable, bit 5 LSB-first, bit 4 master, bit 3 polarity, bit 2 phase, bits 1..0 rate. In master mode the SCK period is 4, 16, 64 or 128 system clocks for rate codes 00, 01, 10 and 11.
- R4: When LSB-first is 1, bit 0 goes out first. When LSB-first is 0, bit 7 goes out first.
- R5: With polarity 0, SCK rests low. With polarity 1, SCK rests high. After each byte SCK returns to that level.
- R6: With phase 0, each bit is valid before the leading SCK edge and is sampled on that edge. With phase 1, data changes on the leading edge and is sampled on the trailing edge.
- R7: In master mode, a data write while the port is idle starts an 8-bit transfer. When it ends, the data register holds the byte sampled from `miso_i` and the completion flag is set.
- R8: A data write during a transfer leaves the outgoing byte unchanged and sets the collision flag.
- R9: The flags clear only when a data read or write follows a status read that found a flag set. A data access with no such prior status read leaves them set.
- R10: `irq_o` is 1 only while the completion flag, control bit 7 and `ser_int_en_i` are all 1.
- R11: While the port enable bit is 0, all three output enables are 0 and no SCK edges occur.
- R12: In slave mode the rate bits have no effect. `miso_oe` is 1 only while `ss_n_i` is low. With phase 0 the first bit is on `miso_o` once select goes low. SCK edges seen while select is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_sel | input | 2 | Register select |
| sfr_wr | input | 1 | Register write strobe |
| sfr_rd | input | 1 | Register read strobe |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Registered read data |
| ser_int_en_i | input | 1 | External serial-interrupt enable |
| irq_o | output | 1 | Interrupt request |
| sck_o | output | 1 | Master serial clock out |
| sck_oe | output | 1 | Serial clock output enable |
| sck_i | input | 1 | Serial clock in (slave) |
| mosi_o | output | 1 | Master data out |
| mosi_oe | output | 1 | Master data output enable |
| mosi_i | input | 1 | Master data in (slave) |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | Slave data output enable |
| miso_i | input | 1 | Slave data in (master) |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
A fault in the edge counter or in the sample/shift choice shows up within one byte. The serial stream seen at the pins comes out in the wrong order or with one bit skewed, and SCK rests at the wrong level once the byte ends. A fault in the clear-sequence arming shows at the next status read: either a flag is still set when it should have cleared, or it cleared after a data access that had no status read before it. A wrong divider limit shows in the measured SCK period on the first pair of leading edges.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  typedef struct packed {
    logic       int_en;
    logic       enable;
    logic       lsb_first;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } spi_ctrl_t;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

  localparam logic [7:0] CTRL_RESET = 8'h04;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else if (i == 0) stg[i] <= d;
        else stg[i] <= stg[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_clkdiv.sv
module spi_clkdiv #(
  parameter int DIV0 = 4,
  parameter int DIV1 = 16,
  parameter int DIV2 = 64,
  parameter int DIV3 = 128
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       tick
);
  localparam int CNT_W = $clog2(DIV3 / 2) + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  always_comb begin
    case (rate)
      2'd0:    lim = CNT_W'(DIV0 / 2 - 1);
      2'd1:    lim = CNT_W'(DIV1 / 2 - 1);
      2'd2:    lim = CNT_W'(DIV2 / 2 - 1);
      default: lim = CNT_W'(DIV3 / 2 - 1);
    endcase
  end

  assign tick = run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == lim) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  p_count_in_range_r3: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt <= lim));
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enable,
  input  logic         master,
  input  logic         cpha,
  input  logic         lsb_first,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         tick,
  input  logic         ss_act,
  input  logic         sck_s,
  input  logic         mosi_s,
  input  logic         miso_i,
  output logic         busy,
  output logic         done,
  output logic         sck_q,
  output logic         out_bit,
  output logic [W-1:0] sreg
);
  localparam int CNT_W = $clog2(2 * W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(2 * W - 1);

  logic [CNT_W-1:0] cnt;
  logic             active_q;
  logic             rx_bit;
  logic             sck_d;
  logic             ev_ok, is_lead, sample_ev, shift_ev, last_ev, abort, in_bit;

  function automatic logic [W-1:0] shift_in(input logic [W-1:0] s, input logic b,
                                            input logic lsb);
    if (lsb) shift_in = {b, s[W-1:1]};
    else     shift_in = {s[W-2:0], b};
  endfunction

  assign busy      = active_q;
  assign out_bit   = lsb_first ? sreg[0] : sreg[W-1];
  assign in_bit    = master ? miso_i : mosi_s;
  assign abort     = !enable || (!master && !ss_act);
  assign ev_ok     = master ? (active_q && tick) : (ss_act && (sck_s != sck_d));
  assign is_lead   = ~cnt[0];
  assign sample_ev = ev_ok && (is_lead ^ cpha);
  assign shift_ev  = ev_ok && !(is_lead ^ cpha) && !(cpha && cnt == '0);
  assign last_ev   = ev_ok && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) sck_d <= 1'b0;
    else     sck_d <= sck_s;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg     <= '0;
      rx_bit   <= 1'b0;
      cnt      <= '0;
      active_q <= 1'b0;
      sck_q    <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        cnt      <= '0;
        active_q <= 1'b0;
        sck_q    <= 1'b0;
        if (load) sreg <= load_data;
      end else if (load) begin
        sreg <= load_data;
        if (master) begin
          active_q <= 1'b1;
          cnt      <= '0;
          sck_q    <= 1'b0;
        end
      end else if (ev_ok) begin
        cnt <= cnt + 1'b1;
        if (master) sck_q <= ~sck_q;
        if (!master) active_q <= 1'b1;
        if (sample_ev) rx_bit <= in_bit;
        if (shift_ev) sreg <= shift_in(sreg, rx_bit, lsb_first);
        if (last_ev) begin
          cnt      <= '0;
          active_q <= 1'b0;
          done     <= 1'b1;
          if (cpha) sreg <= shift_in(sreg, in_bit, lsb_first);
        end
      end
    end
  end

  p_idle_level_r5: assert property (@(posedge clk) disable iff (rst)
    !active_q |-> !sck_q);

  p_no_change_between_edges_r8: assert property (@(posedge clk) disable iff (rst)
    (active_q && master && enable && !ev_ok) |=> $stable(sreg));

  p_done_ends_busy_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !active_q);
endmodule

// File: rtl/spi_regs.sv
module spi_regs
  import spi_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   sfr_sel,
  input  logic         sfr_wr,
  input  logic         sfr_rd,
  input  logic [W-1:0] sfr_wdata,
  input  logic         done,
  input  logic         busy,
  input  logic [W-1:0] sreg,
  input  logic         ser_int_en_i,
  output spi_ctrl_t    ctrl,
  output logic         data_load,
  output logic [W-1:0] sfr_rdata,
  output logic         irq_o
);
  logic spif, wcol, armed;
  logic data_wr, data_acc, stat_rd, clr;

  assign data_wr   = sfr_wr && (sfr_sel == SEL_DATA);
  assign data_acc  = (sfr_wr || sfr_rd) && (sfr_sel == SEL_DATA);
  assign stat_rd   = sfr_rd && (sfr_sel == SEL_STAT);
  assign data_load = data_wr && !busy;
  assign clr       = data_acc && armed;

  always_ff @(posedge clk) begin
    if (rst) ctrl <= spi_ctrl_t'(CTRL_RESET);
    else if (sfr_wr && sfr_sel == SEL_CTRL) ctrl <= spi_ctrl_t'(sfr_wdata);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      spif  <= 1'b0;
      wcol  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (stat_rd) armed <= spif || wcol;
      else if (data_acc) armed <= 1'b0;
      if (done) spif <= 1'b1;
      else if (clr) spif <= 1'b0;
      if (data_wr && busy) wcol <= 1'b1;
      else if (clr) wcol <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sfr_rdata <= '0;
    else if (sfr_rd) begin
      case (sfr_sel)
        SEL_CTRL: sfr_rdata <= W'(ctrl);
        SEL_STAT: sfr_rdata <= {spif, wcol, {(W-2){1'b0}}};
        SEL_DATA: sfr_rdata <= sreg;
        default:  sfr_rdata <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= spif && ctrl.int_en && ser_int_en_i;
  end

  p_collide_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (data_wr && busy) |=> wcol);

  p_done_flag_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> spif);

  p_irq_gate_r10: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(spif && ctrl.int_en && ser_int_en_i));

  p_clear_needs_access_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(spif) |-> $past(data_acc));
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int W = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DIV0 = 4,
  parameter int DIV1 = 16,
  parameter int DIV2 = 64,
  parameter int DIV3 = 128
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sfr_sel,
  input  logic       sfr_wr,
  input  logic       sfr_rd,
  input  logic [7:0] sfr_wdata,
  output logic [7:0] sfr_rdata,
  input  logic       ser_int_en_i,
  output logic       irq_o,
  output logic       sck_o,
  output logic       sck_oe,
  input  logic       sck_i,
  output logic       mosi_o,
  output logic       mosi_oe,
  input  logic       mosi_i,
  output logic       miso_o,
  output logic       miso_oe,
  input  logic       miso_i,
  input  logic       ss_n_i
);
  spi_ctrl_t ctrl;
  logic      data_load, busy, done, sck_q, out_bit, tick;
  logic      ss_n_s, sck_s, mosi_s;
  logic [W-1:0] sreg;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
    .clk(clk), .rst(rst),
    .d({ss_n_i, sck_i, mosi_i}),
    .q({ss_n_s, sck_s, mosi_s})
  );

  spi_regs #(.W(W)) i_regs (
    .clk(clk), .rst(rst),
    .sfr_sel(sfr_sel), .sfr_wr(sfr_wr), .sfr_rd(sfr_rd), .sfr_wdata(sfr_wdata),
    .done(done), .busy(busy), .sreg(sreg), .ser_int_en_i(ser_int_en_i),
    .ctrl(ctrl), .data_load(data_load), .sfr_rdata(sfr_rdata), .irq_o(irq_o)
  );

  spi_clkdiv #(.DIV0(DIV0), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)) i_div (
    .clk(clk), .rst(rst),
    .run(busy && ctrl.master && ctrl.enable),
    .rate(ctrl.rate), .tick(tick)
  );

  spi_shifter #(.W(W)) i_shift (
    .clk(clk), .rst(rst),
    .enable(ctrl.enable), .master(ctrl.master), .cpha(ctrl.cpha),
    .lsb_first(ctrl.lsb_first), .load(data_load), .load_data(sfr_wdata),
    .tick(tick), .ss_act(!ss_n_s), .sck_s(sck_s), .mosi_s(mosi_s), .miso_i(miso_i),
    .busy(busy), .done(done), .sck_q(sck_q), .out_bit(out_bit), .sreg(sreg)
  );

  assign sck_o  = ctrl.cpol ^ sck_q;
  assign mosi_o = out_bit;
  assign miso_o = out_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_oe  <= 1'b0;
      mosi_oe <= 1'b0;
      miso_oe <= 1'b0;
    end else begin
      sck_oe  <= ctrl.enable && ctrl.master;
      mosi_oe <= ctrl.enable && ctrl.master;
      miso_oe <= ctrl.enable && !ctrl.master && !ss_n_s;
    end
  end

  p_release_r11: assert property (@(posedge clk) disable iff (rst)
    !ctrl.enable |=> (!sck_oe && !mosi_oe && !miso_oe));
endmodule

// File: tb/test_spi_port.sv
module test_spi_port;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] sfr_sel = '0;
  logic sfr_wr = 1'b0, sfr_rd = 1'b0;
  logic [7:0] sfr_wdata = '0;
  logic [7:0] sfr_rdata;
  logic ser_int_en_i = 1'b0;
  logic irq_o, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe;
  logic sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;
  logic miso_i;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  // monitor state
  bit   mon_on = 0;
  logic mon_cpol = 0, mon_cpha = 0;
  logic mon_prev_sck = 0, mon_prev_mosi = 0, lead;
  logic [7:0] mon_bits;
  int   mon_cnt = 0, mon_leads = 0, l0 = 0, l1 = 0, cyc = 0;

  assign miso_i = mosi_o;  // loopback

  spi_port i_spi_port (
    .clk(clk), .rst(rst), .sfr_sel(sfr_sel), .sfr_wr(sfr_wr), .sfr_rd(sfr_rd),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .ser_int_en_i(ser_int_en_i),
    .irq_o(irq_o), .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i), .mosi_o(mosi_o),
    .mosi_oe(mosi_oe), .mosi_i(mosi_i), .miso_o(miso_o), .miso_oe(miso_oe),
    .miso_i(miso_i), .ss_n_i(ss_n_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    if (mon_on && sck_oe && sck_o != mon_prev_sck) begin
      lead = (sck_o != mon_cpol);
      if (lead) begin
        if (mon_leads == 0) l0 = cyc;
        else if (mon_leads == 1) l1 = cyc;
        mon_leads++;
      end
      if (lead != mon_cpha) begin
        if (mon_cnt < 8) mon_bits[mon_cnt] = mon_prev_mosi;
        mon_cnt++;
      end
    end
    mon_prev_sck  = sck_o;
    mon_prev_mosi = mosi_o;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); sfr_sel = sel; sfr_wdata = d; sfr_wr = 1'b1;
    @(negedge clk); sfr_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk); sfr_sel = sel; sfr_rd = 1'b1;
    @(negedge clk); sfr_rd = 1'b0; d = sfr_rdata;
  endtask

  task automatic mon_reset(input logic cpol, input logic cpha);
    mon_cpol = cpol; mon_cpha = cpha;
    mon_cnt = 0; mon_leads = 0; l0 = 0; l1 = 0; mon_bits = '0; mon_on = 1;
  endtask

  task automatic wait_byte();
    for (int n = 0; n < 5000 && mon_cnt < 8; n++) @(negedge clk);
    repeat (80) @(negedge clk);
  endtask

  function automatic logic [7:0] stream_byte(input logic lsb);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) b[lsb ? i : 7-i] = mon_bits[i];
    return b;
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    check(!sck_oe && !mosi_oe && !miso_oe, "R1 oe after reset", {sck_oe, mosi_oe, miso_oe}, 0);
    check(irq_o == 1'b0, "R1 irq after reset", irq_o, 0);
    rd(2'd0, d); check(d == 8'h04, "R1 ctrl reset / R2 ctrl read", d, 8'h04);
    rd(2'd1, d); check(d == 8'h00, "R1 status reset", d, 0);
  endtask

  task automatic t_master(input logic cpol, input logic cpha, input logic lsb,
                          input logic [1:0] rate, input logic [7:0] data);
    logic [7:0] d;
    int per;
    per = (rate == 0) ? 4 : (rate == 1) ? 16 : (rate == 2) ? 64 : 128;
    wr(2'd0, {1'b0, 1'b1, lsb, 1'b1, cpol, cpha, rate});
    repeat (2) @(negedge clk);
    check(sck_o == cpol, "R5 idle level before", sck_o, cpol);
    check(sck_oe && mosi_oe, "R11 master oe on", {sck_oe, mosi_oe}, 3);
    mon_reset(cpol, cpha);
    wr(2'd2, data);
    wait_byte();
    check(mon_cnt == 8, "R7 eight sample edges", mon_cnt, 8);
    check(l1 - l0 == per, "R3 sck period", l1 - l0, per);
    check(stream_byte(lsb) == data, "R4 R6 serial stream order/phase", stream_byte(lsb), data);
    check(sck_o == cpol, "R5 idle level after", sck_o, cpol);
    rd(2'd2, d); check(d == data, "R7 loopback receive", d, data);
    rd(2'd1, d); check(d == 8'h80, "R9 data access alone keeps flag / R2", d, 8'h80);
    rd(2'd2, d);
    rd(2'd1, d); check(d == 8'h00, "R9 clear sequence", d, 0);
    mon_on = 0;
  endtask

  task automatic t_collision();
    logic [7:0] d;
    wr(2'd0, 8'h55);  // enabled, master, cpol0, cpha1, rate 01
    repeat (2) @(negedge clk);
    mon_reset(1'b0, 1'b1);
    wr(2'd2, 8'h71);
    repeat (20) @(negedge clk);
    wr(2'd2, 8'h0F);
    rd(2'd1, d); check(d == 8'h40, "R8 collision flag during transfer", d, 8'h40);
    wait_byte();
    check(stream_byte(1'b0) == 8'h71, "R8 stream unchanged by write", stream_byte(1'b0), 8'h71);
    rd(2'd1, d); check(d == 8'hC0, "R8 both flags set", d, 8'hC0);
    rd(2'd2, d); check(d == 8'h71, "R8 data register unchanged", d, 8'h71);
    rd(2'd1, d); check(d == 8'h00, "R9 both flags cleared", d, 0);
    mon_on = 0;
  endtask

  task automatic t_irq();
    logic [7:0] d;
    wr(2'd0, 8'hD0);
    repeat (2) @(negedge clk);
    mon_reset(1'b0, 1'b0);
    wr(2'd2, 8'h3C);
    wait_byte();
    check(irq_o == 1'b0, "R10 irq gated by external enable", irq_o, 0);
    ser_int_en_i = 1'b1;
    repeat (3) @(negedge clk);
    check(irq_o == 1'b1, "R10 irq asserted", irq_o, 1);
    rd(2'd1, d); rd(2'd2, d);
    repeat (3) @(negedge clk);
    check(irq_o == 1'b0, "R10 irq drops after clear", irq_o, 0);
    ser_int_en_i = 1'b0;
    mon_on = 0;
  endtask

  task automatic t_disable();
    logic [7:0] d;
    wr(2'd0, 8'h10);
    repeat (3) @(negedge clk);
    mon_reset(1'b0, 1'b0);
    check(!sck_oe && !mosi_oe && !miso_oe, "R11 oe released", {sck_oe, mosi_oe, miso_oe}, 0);
    wr(2'd2, 8'hAA);
    repeat (200) @(negedge clk);
    check(mon_cnt == 0 && sck_o == 1'b0, "R11 no sck activity", mon_cnt, 0);
    rd(2'd1, d); check(d == 8'h00, "R11 no completion when disabled", d, 0);
    mon_on = 0;
  endtask

  task automatic t_slave(input logic cpol, input logic cpha, input logic lsb,
                         input logic [7:0] txd, input logic [7:0] rxd);
    logic [7:0] d, got;
    int idx;
    wr(2'd0, {1'b0, 1'b1, lsb, 1'b0, cpol, cpha, 2'b11});
    @(negedge clk); ss_n_i = 1'b1; sck_i = cpol;
    wr(2'd2, txd);
    for (int k = 0; k < 4; k++) begin
      repeat (8) @(negedge clk); sck_i = ~sck_i;
    end
    repeat (8) @(negedge clk);
    check(miso_oe == 1'b0, "R12 miso released while deselected", miso_oe, 0);
    rd(2'd1, d); check(d == 8'h00, "R12 sck ignored while deselected", d, 0);
    mosi_i = rxd[lsb ? 0 : 7];
    ss_n_i = 1'b0;
    repeat (8) @(negedge clk);
    check(miso_oe == 1'b1, "R12 miso driven when selected", miso_oe, 1);
    if (!cpha) check(miso_o == txd[lsb ? 0 : 7], "R12 first bit on select", miso_o, txd[lsb ? 0 : 7]);
    got = '0;
    for (int i = 0; i < 8; i++) begin
      idx = lsb ? i : 7 - i;
      if (!cpha) begin
        mosi_i = rxd[idx];
        repeat (8) @(negedge clk);
        got[idx] = miso_o;
        sck_i = ~cpol;
        repeat (8) @(negedge clk);
        sck_i = cpol;
      end else begin
        sck_i = ~cpol;
        mosi_i = rxd[idx];
        repeat (8) @(negedge clk);
        got[idx] = miso_o;
        sck_i = cpol;
        repeat (8) @(negedge clk);
      end
    end
    repeat (8) @(negedge clk);
    ss_n_i = 1'b1;
    repeat (6) @(negedge clk);
    check(got == txd, "R12 slave transmit", got, txd);
    rd(2'd1, d); check(d == 8'h80, "R12 slave completion", d, 8'h80);
    rd(2'd2, d); check(d == rxd, "R12 slave receive", d, rxd);
    rd(2'd1, d); check(d == 8'h00, "R9 slave flag clear", d, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_master(1'b0, 1'b0, 1'b0, 2'd0, 8'hA5);
    t_master(1'b0, 1'b1, 1'b1, 2'd1, 8'h3C);
    t_master(1'b1, 1'b0, 1'b0, 2'd2, 8'hC1);
    t_master(1'b1, 1'b1, 1'b1, 2'd3, 8'h5E);
    t_master(1'b1, 1'b1, 1'b0, 2'd0, 8'h96);
    t_master(1'b0, 1'b0, 1'b1, 2'd0, 8'h81);
    t_collision();
    t_irq();
    t_disable();
    t_slave(1'b0, 1'b0, 1'b0, 8'h3A, 8'hC5);
    t_slave(1'b1, 1'b1, 1'b1, 8'h6B, 8'h92);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule